// File: doc/BRIEF.md
# PCI Interrupt Link Router

This block connects eight shareable PCI interrupt links to a sixteen-line legacy interrupt bus. Each link has a small byte-wide routing register. The register either names the legacy line the link is steered to or marks the link as switched off. Several devices can share one link, and each device drives its own level-sensitive request wire. A link counts as active while any of its request wires is high.

Each legacy output is the OR of every active link that is routed to it with a usable setting. Software programs the routes through a plain register port: an index, a write strobe with its data, and a read strobe whose data appears one cycle later.

Only a fixed set of legacy line numbers can be targeted. A register that names any other line behaves exactly like a disabled one. Rewriting a register while its link is active moves the request to the new line at one clock edge, so the old line drops and the new line rises together.

Top module: `pci_link_router`

## Requirements
- R1: After reset every routing register reads 0x80, `reg_rdata` is 0x00 and `irq` is all zero.
- R2: A write to link index 0..7 stores bit 7 and bits 3:0 of `reg_wdata` and clears bits 6:4. A read strobe returns the addressed register on `reg_rdata` in the following cycle, and `reg_rdata` holds that value until the next read strobe.
- R3: A write with an index of 8 or above changes no register. A read with such an index returns 0x00.
- R4: A link whose register has bit 7 set drives no `irq` line, whatever its requests are.
- R5: A link whose bits 3:0 select line 0, 1, 2, 8 or 13 drives no `irq` line, even with bit 7 clear. These five `irq` bits are always 0. The usable lines are 3–7, 9–12, 14 and 15 (mask 0xDEF8).
- R6: A link is active while at least one of its request wires is high. Its routed line is high from the first rising request until the last one falls.
- R7: When several links are routed to the same line, that line is the OR of their activity.
- R8: A write that changes the register of an active link moves its contribution from the old line to the new usable line at the clock edge that stores the write.
- R9: A write of the value a register already holds leaves `irq` and the register contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_idx | input | 4 | Link index for register access (0..7 valid) |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_re` |
| link_req | input | 32 | Request wires; link L, requester k on bit L*4+k |
| irq | output | 16 | Legacy interrupt lines, level, active high |

## Verification
The bench builds the block with its default parameters: eight links, four requesters per link and a four-bit index. Because the index is four bits wide, indices 8 to 15 can be driven, which exercises the ignored-write and zero-read paths. Because each link has four requesters, the bench can test sharing inside a link (raise two, drop one) separately from sharing between links. A reference model rebuilds the expected `irq` from the written values and the requests, and it is checked against all sixteen target values, including the five reserved ones.

// File: rtl/pci_link_pkg.sv
// Package: shared constants and helper functions for the link router.
// Assumes an 8-bit routing byte: bit 7 = off flag, bits 3:0 = target line.
package pci_link_pkg;
    localparam int ROUTE_W = 8;
    localparam int TGT_W   = 4;
    localparam int OFF_BIT = 7;

    // Keep only the off flag and the target field of a written byte.
    function automatic logic [ROUTE_W-1:0] scrub_route(input logic [ROUTE_W-1:0] v);
        return {v[OFF_BIT], 3'b000, v[TGT_W-1:0]};
    endfunction

    // True when a routing byte is enabled and names a usable line.
    function automatic logic route_usable(input logic [ROUTE_W-1:0] r,
                                          input logic [(1<<TGT_W)-1:0] mask);
        return !r[OFF_BIT] && mask[r[TGT_W-1:0]];
    endfunction
endpackage

// File: rtl/link_route_regs.sv
// Module: link_route_regs
// Holds one routing byte per link, with a write port and a registered read port.
// Assumes: reg_idx can exceed the link count; such writes are dropped and
// such reads return zero. Reset sets every link to the "off" value.
module link_route_regs
    import pci_link_pkg::*;
#(
    parameter int NUM_LINKS = 8,
    parameter int IDX_W     = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [IDX_W-1:0]                      reg_idx,
    input  logic                                  reg_we,
    input  logic                                  reg_re,
    input  logic [ROUTE_W-1:0]                    reg_wdata,
    output logic [ROUTE_W-1:0]                    reg_rdata,
    output logic [NUM_LINKS-1:0][ROUTE_W-1:0]     route_o
);
    localparam int SEL_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1;
    localparam logic [ROUTE_W-1:0] OFF_VALUE = ROUTE_W'(1) << OFF_BIT;

    logic [NUM_LINKS-1:0][ROUTE_W-1:0] route_q;
    logic [SEL_W-1:0]                  sel;
    logic                              in_range;

    // Decode the index into a link select and a range flag.
    always_comb begin
        sel      = reg_idx[SEL_W-1:0];
        in_range = (reg_idx < IDX_W'(NUM_LINKS));
    end

    // Routing storage: reset to off, write the scrubbed byte when addressed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < NUM_LINKS; l++) route_q[l] <= OFF_VALUE;
        end else if (reg_we && in_range) begin
            route_q[sel] <= scrub_route(reg_wdata);
        end
    end

    // Read data register: loads on a read strobe, zero for out-of-range.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_re) reg_rdata <= in_range ? route_q[sel] : '0;
    end

    assign route_o = route_q;

    AST_WRITE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && in_range) |=> route_q[$past(sel)] == scrub_route($past(reg_wdata))); // R2
    AST_RDATA_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[6:4] == 3'b000); // R2
    AST_OOR_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !in_range) |=> route_q == $past(route_q)); // R3
endmodule

// File: rtl/link_activity.sv
// Module: link_activity
// Folds each link's group of sharing request wires into one active flag.
// Assumes requests are level signals already synchronous to the clock.
module link_activity #(
    parameter int NUM_LINKS = 8,
    parameter int REQS      = 4
) (
    input  logic [NUM_LINKS*REQS-1:0] link_req,
    output logic [NUM_LINKS-1:0]      active
);
    for (genvar l = 0; l < NUM_LINKS; l++) begin : g_link
        // A link is active while any of its requesters is high.
        assign active[l] = |link_req[l*REQS +: REQS];
    end
endmodule

// File: rtl/irq_route_fanout.sv
// Module: irq_route_fanout
// Steers active links onto legacy lines as a purely combinational OR matrix.
// Assumes the routing bytes come from registers, so a rewrite switches the
// old and new line at the same clock edge.
module irq_route_fanout
    import pci_link_pkg::*;
#(
    parameter int NUM_LINKS = 8,
    parameter int NUM_IRQ   = 1 << TGT_W,
    parameter logic [NUM_IRQ-1:0] PERMIT_MASK = 16'hDEF8
) (
    input  logic [NUM_LINKS-1:0][ROUTE_W-1:0] route,
    input  logic [NUM_LINKS-1:0]              active,
    output logic [NUM_IRQ-1:0]                irq
);
    logic [NUM_LINKS-1:0] drives;

    for (genvar l = 0; l < NUM_LINKS; l++) begin : g_drive
        // A link drives only when active and routed to a usable line.
        assign drives[l] = active[l] && route_usable(route[l], PERMIT_MASK);
    end

    for (genvar j = 0; j < NUM_IRQ; j++) begin : g_line
        logic [NUM_LINKS-1:0] hit;
        for (genvar l = 0; l < NUM_LINKS; l++) begin : g_hit
            // This link contributes to line j when it targets j.
            assign hit[l] = drives[l] && (route[l][TGT_W-1:0] == TGT_W'(j));
        end
        // Line j is the OR of its contributors, gated by the permit mask.
        assign irq[j] = PERMIT_MASK[j] & (|hit);
    end
endmodule

// File: rtl/pci_link_router.sv
// Module: pci_link_router (top)
// Eight interrupt links with shared level requests routed onto sixteen
// legacy lines through per-link routing bytes.
// Assumes synchronous active-low reset and an index port wider than needed.
module pci_link_router
    import pci_link_pkg::*;
#(
    parameter int NUM_LINKS = 8,
    parameter int REQS      = 4,
    parameter int IDX_W     = 4,
    parameter logic [15:0] PERMIT_MASK = 16'hDEF8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [IDX_W-1:0]          reg_idx,
    input  logic                      reg_we,
    input  logic                      reg_re,
    input  logic [7:0]                reg_wdata,
    output logic [7:0]                reg_rdata,
    input  logic [NUM_LINKS*REQS-1:0] link_req,
    output logic [15:0]               irq
);
    localparam int NUM_IRQ = 1 << TGT_W;

    logic [NUM_LINKS-1:0][ROUTE_W-1:0] route;
    logic [NUM_LINKS-1:0]              active;
    logic [NUM_LINKS-1:0]              usable;

    link_route_regs #(.NUM_LINKS(NUM_LINKS), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_idx   (reg_idx),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .route_o   (route)
    );

    link_activity #(.NUM_LINKS(NUM_LINKS), .REQS(REQS)) u_act (
        .link_req (link_req),
        .active   (active)
    );

    irq_route_fanout #(.NUM_LINKS(NUM_LINKS), .NUM_IRQ(NUM_IRQ),
                       .PERMIT_MASK(PERMIT_MASK)) u_fan (
        .route  (route),
        .active (active),
        .irq    (irq)
    );

    for (genvar l = 0; l < NUM_LINKS; l++) begin : g_use
        // Per-link usability, used only by the checks below.
        assign usable[l] = route_usable(route[l], PERMIT_MASK);
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (link_req == '0) |-> (irq == '0)); // R6
    AST_NO_ROUTE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (usable == '0) |-> (irq == '0)); // R4
    AST_RESERVED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~PERMIT_MASK) == '0); // R5
endmodule

// File: tb/pci_link_router_tb.sv
`timescale 1ns/1ps
module pci_link_router_tb;
    localparam int NL = 8;
    localparam int NR = 4;
    localparam logic [15:0] MASK = 16'hDEF8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_idx = '0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [NL*NR-1:0] link_req = '0;
    logic [15:0] irq;

    always #4 clk = ~clk;

    pci_link_router u_dut (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_we(reg_we),
        .reg_re(reg_re), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .link_req(link_req), .irq(irq)
    );

    typedef struct {
        int          due;
        bit          is_read;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    logic [7:0] m_route [NL];

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop items when due and compare against the outputs.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            logic [15:0] act;
            it = q.pop_front();
            act = it.is_read ? {8'h00, reg_rdata} : irq;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    function automatic logic [15:0] model_irq();
        logic [15:0] r = '0;
        for (int l = 0; l < NL; l++)
            if (|link_req[l*NR +: NR] && !m_route[l][7] && MASK[m_route[l][3:0]])
                r[m_route[l][3:0]] = 1'b1;
        return r;
    endfunction

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr(input int idx, input logic [7:0] v);
        step();
        reg_idx = 4'(idx); reg_wdata = v; reg_we = 1'b1;
        if (idx < NL) m_route[idx] = {v[7], 3'b000, v[3:0]};
        step();
        reg_we = 1'b0;
    endtask

    task automatic rd(input int idx, input logic [7:0] e, input string tag);
        step();
        reg_idx = 4'(idx); reg_re = 1'b1;
        q.push_back('{cyc + 1, 1'b1, {8'h00, e}, tag});
        step();
        reg_re = 1'b0;
    endtask

    task automatic chk_irq(input logic [15:0] e, input string tag);
        step();
        q.push_back('{cyc, 1'b0, e, tag});
    endtask

    task automatic set_req(input logic [NL*NR-1:0] v);
        step();
        link_req = v;
    endtask

    task automatic direct(input bit ok, input logic [15:0] a, input logic [15:0] e,
                          input string tag);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, a, e);
        end
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int l = 0; l < NL; l++) m_route[l] = 8'h80;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        direct(reg_rdata == 8'h00, {8'h0, reg_rdata}, 16'h0, "R1 rdata after reset");
        direct(irq == 16'h0, irq, 16'h0, "R1 irq after reset");

        // R1: all registers start off
        for (int l = 0; l < NL; l++) rd(l, 8'h80, "R1 reset value");
        set_req('1);
        chk_irq(16'h0000, "R1 all links off");
        set_req('0);

        // R2: reserved bits cleared, readback next cycle
        wr(0, 8'hFB);
        rd(0, 8'h8B, "R2 scrub with off flag");
        wr(0, 8'h75);
        rd(0, 8'h05, "R2 scrub enabled");
        step();
        q.push_back('{cyc, 1'b1, 16'h0005, "R2 rdata holds"});

        // R3: out-of-range write ignored, read gives zero
        wr(9, 8'h03);
        wr(15, 8'h04);
        rd(9, 8'h00, "R3 oor read");
        for (int l = 0; l < NL; l++) rd(l, m_route[l], "R3 regs unchanged");

        // R6: requester sharing within one link
        set_req(32'h0000_0002);
        chk_irq(16'h0020, "R6 first requester");
        set_req(32'h0000_000A);
        chk_irq(16'h0020, "R6 two requesters");
        set_req(32'h0000_0008);
        chk_irq(16'h0020, "R6 one left");
        set_req(32'h0000_0000);
        chk_irq(16'h0000, "R6 last released");

        // R4: off flag blocks an active link
        set_req(32'h0000_0001);
        wr(0, 8'h85);
        chk_irq(16'h0000, "R4 disabled link");
        wr(0, 8'h05);
        chk_irq(16'h0020, "R4 re-enabled");

        // R5: reserved targets never drive
        wr(0, 8'h00); chk_irq(16'h0000, "R5 target 0");
        wr(0, 8'h01); chk_irq(16'h0000, "R5 target 1");
        wr(0, 8'h02); chk_irq(16'h0000, "R5 target 2");
        wr(0, 8'h08); chk_irq(16'h0000, "R5 target 8");
        wr(0, 8'h0D); chk_irq(16'h0000, "R5 target 13");

        // R7: two links share line 10
        wr(1, 8'h0A);
        wr(2, 8'h0A);
        set_req(32'h0000_0110);
        chk_irq(16'h0400, "R7 both links");
        set_req(32'h0000_0100);
        chk_irq(16'h0400, "R7 one link left");
        set_req(32'h0000_0000);
        chk_irq(16'h0000, "R7 none");

        // R8: reroute while active, checked right after the storing edge
        wr(0, 8'h05);
        set_req(32'h0000_0001);
        chk_irq(16'h0020, "R8 before move");
        step();
        reg_idx = 4'd0; reg_wdata = 8'h09; reg_we = 1'b1; m_route[0] = 8'h09;
        step();
        reg_we = 1'b0;
        q.push_back('{cyc, 1'b0, 16'h0200, "R8 moved same edge"});

        // R9: same-value rewrite has no effect
        wr(0, 8'h09);
        chk_irq(16'h0200, "R9 irq unchanged");
        rd(0, 8'h09, "R9 reg unchanged");

        // Sweep every target on link 3 against the model
        set_req(32'h0000_1000);
        for (int t = 0; t < 16; t++) begin
            wr(3, 8'(t));
            chk_irq(model_irq(), (MASK[t] ? "R6 sweep usable" : "R5 sweep reserved"));
        end
        set_req('0);
        chk_irq(16'h0000, "R6 sweep idle");

        repeat (3) step();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule